// File: doc/BRIEF.md
# Strap-Selected Slave Address Controller

This block gives a control-bus slave its 4-bit unique slave address and the small set of identity registers around it. At reset the address is taken from a four-entry strap table. The table is indexed by the level of an address-select pin and by a flag that says whether the clock and data wires were swapped on the board. Once reset is released, the pins are no longer looked at. No fused value is involved.

After reset, a host can move the device to a new address. It does this with a fixed three-write unlock sequence. The first write goes to the product identity register and carries its own value. The second goes to the manufacturer identity register and carries its own value. The third goes to the address register and carries the new address. A write that follows any other path to the address register is dropped.

The block also answers reads of its read-only identity registers. It holds a writable group address nibble. Read data appears one clock after the read strobe. Detecting swapped wiring from line activity happens elsewhere and reaches this block as the `swap_mode` input.

Top module: `usid_strap_ctl`

## Requirements
- R1: With `swap_mode`=0 and `sel_high`=0 during a synchronous reset, `usid` is 4'b0111 on the first clock after reset is released.
- R2: With `swap_mode`=0 and `sel_high`=1 during reset, `usid` is 4'b0110 after reset.
- R3: With `swap_mode`=1 during reset, `usid` is 4'b1100 when `sel_high`=0 and 4'b0010 when `sel_high`=1.
- R4: Changes on `sel_high` or `swap_mode` after reset do not change `usid`.
- R5: A read of address 0x1F returns {2'b00, 2'b01, usid} on `rdata` in the cycle after `rd_en`. Bits 3:0 carry the address, bits 5:4 the upper maker code, and bits 7:6 are zero. `rdata` holds its value while `rd_en` is low.
- R6: Reads of 0x1D, 0x1E and 0x20 return 0x32, 0x1A and 0x00. Writes of any data to these addresses leave those read values unchanged.
- R7: A write of 0x32 to 0x1D, then a write of 0x1A to 0x1E, then a write to 0x1F loads wdata[3:0] into `usid` one clock after the 0x1F write. Idle cycles with no strobe may sit between the steps.
- R8: The 0x1F write does not change `usid` in any of these cases: wrong data in either unlock write, an intervening read or other write, steps out of order, a bare 0x1F write, or `wr_en` and `rd_en` high together.
- R9: Address 0x22 holds a writable group address in bits 7:4 that resets to 0. Bits 3:0 always read 0.
- R10: Reset discards a programmed address and restores the strap value. It also clears the group address.
- R11: Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or supply-driven) |
| sel_high | input | 1 | Level of the address-select strap pin |
| swap_mode | input | 1 | 1 when clock and data wires are swapped |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| usid | output | 4 | Current unique slave address |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
A bad strap entry shows up on `usid` on the first clock after reset. An unlock sequence stuck in the wrong step shows up as a missing or spurious address change one clock after the 0x1F write. In both cases a readback of 0x1F confirms the value one cycle later. Wrong identity constants or a leaky group nibble show up on `rdata` in the cycle after the read. This is why every strap combination, every programmable address value, and the whole address space are swept.

// File: rtl/usid_pkg.sv
package usid_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_PID_OK = 2'd1,
      SEQ_MID_OK = 2'd2
   } seq_state_e;

   localparam int unsigned STRAP_ENTRIES = 4;

   function automatic logic [1:0] strap_index(input logic swap, input logic sel);
      return {swap, sel};
   endfunction

endpackage

// File: rtl/usid_strap_table.sv
module usid_strap_table #(
   parameter int unsigned ID_W       = 4,
   parameter logic [ID_W-1:0] ID_NORM_LO = 4'b0111,
   parameter logic [ID_W-1:0] ID_NORM_HI = 4'b0110,
   parameter logic [ID_W-1:0] ID_SWAP_LO = 4'b1100,
   parameter logic [ID_W-1:0] ID_SWAP_HI = 4'b0010
) (
   input  logic            sel_high,
   input  logic            swap_mode,
   output logic [ID_W-1:0] strap_id
);
   import usid_pkg::*;

   logic [ID_W-1:0] table_q [STRAP_ENTRIES];

   assign table_q[0] = ID_NORM_LO;
   assign table_q[1] = ID_NORM_HI;
   assign table_q[2] = ID_SWAP_LO;
   assign table_q[3] = ID_SWAP_HI;

   always_comb begin
      strap_id = table_q[strap_index(swap_mode, sel_high)];
   end

endmodule

// File: rtl/usid_prog_seq.sv
module usid_prog_seq #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ID_W   = 4,
   parameter logic [ADDR_W-1:0] PID_ADDR  = 8'h1D,
   parameter logic [ADDR_W-1:0] MID_ADDR  = 8'h1E,
   parameter logic [ADDR_W-1:0] USID_ADDR = 8'h1F,
   parameter logic [DATA_W-1:0] PID_VAL   = 8'h32,
   parameter logic [DATA_W-1:0] MID_VAL   = 8'h1A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ID_W-1:0]   strap_id,
   output logic [ID_W-1:0]   usid
);
   import usid_pkg::*;

   seq_state_e state_q, state_d;
   logic       any_access;
   logic       clean_wr;
   logic       pid_hit;
   logic       mid_hit;
   logic       load_hit;

   assign any_access = wr_en | rd_en;
   assign clean_wr   = wr_en & ~rd_en;
   assign pid_hit    = clean_wr && (addr == PID_ADDR) && (wdata == PID_VAL);
   assign mid_hit    = clean_wr && (addr == MID_ADDR) && (wdata == MID_VAL);
   assign load_hit   = clean_wr && (addr == USID_ADDR) && (state_q == SEQ_MID_OK);

   always_comb begin
      state_d = state_q;
      if (any_access) begin
         if (pid_hit) begin
            state_d = SEQ_PID_OK;
         end else if ((state_q == SEQ_PID_OK) && mid_hit) begin
            state_d = SEQ_MID_OK;
         end else begin
            state_d = SEQ_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         usid    <= strap_id;
      end else begin
         state_q <= state_d;
         if (load_hit) begin
            usid <= wdata[ID_W-1:0];
         end
      end
   end

endmodule

// File: rtl/usid_id_regs.sv
module usid_id_regs #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ID_W    = 4,
   parameter int unsigned GID_LSB = 4,
   parameter bit          READ_REG = 1'b1,
   parameter logic [ADDR_W-1:0] PID_ADDR  = 8'h1D,
   parameter logic [ADDR_W-1:0] MID_ADDR  = 8'h1E,
   parameter logic [ADDR_W-1:0] USID_ADDR = 8'h1F,
   parameter logic [ADDR_W-1:0] EXT_ADDR  = 8'h20,
   parameter logic [ADDR_W-1:0] GID_ADDR  = 8'h22,
   parameter logic [DATA_W-1:0] PID_VAL   = 8'h32,
   parameter logic [DATA_W-1:0] MID_VAL   = 8'h1A,
   parameter logic [DATA_W-1:0] EXT_VAL   = 8'h00,
   parameter logic [1:0]        MAKER_HI  = 2'b01
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:GID_LSB]   gid_wdata,
   input  logic [ID_W-1:0]           usid,
   output logic [DATA_W-1:0]         rdata
);
   localparam int unsigned GID_W = DATA_W - GID_LSB;
   localparam int unsigned RSV_W = DATA_W - ID_W - 2;

   logic [GID_W-1:0]  gid_q;
   logic [DATA_W-1:0] mux_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gid_q <= '0;
      end else if (wr_en && (addr == GID_ADDR)) begin
         gid_q <= gid_wdata;
      end
   end

   always_comb begin
      unique case (addr)
         PID_ADDR:  mux_val = PID_VAL;
         MID_ADDR:  mux_val = MID_VAL;
         USID_ADDR: mux_val = {{RSV_W{1'b0}}, MAKER_HI, usid};
         EXT_ADDR:  mux_val = EXT_VAL;
         GID_ADDR:  mux_val = {gid_q, {GID_LSB{1'b0}}};
         default:   mux_val = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata_q <= '0;
            end else if (rd_en) begin
               rdata_q <= mux_val;
            end
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? mux_val : '0;
      end
   endgenerate

endmodule

// File: rtl/usid_strap_ctl.sv
module usid_strap_ctl #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned GID_LSB  = 4,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_high,
   input  logic              swap_mode,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ID_W-1:0]   usid,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] PID_ADDR  = ADDR_W'(8'h1D);
   localparam logic [ADDR_W-1:0] MID_ADDR  = ADDR_W'(8'h1E);
   localparam logic [ADDR_W-1:0] USID_ADDR = ADDR_W'(8'h1F);
   localparam logic [ADDR_W-1:0] EXT_ADDR  = ADDR_W'(8'h20);
   localparam logic [ADDR_W-1:0] GID_ADDR  = ADDR_W'(8'h22);
   localparam logic [DATA_W-1:0] PID_VAL   = DATA_W'(8'h32);
   localparam logic [DATA_W-1:0] MID_VAL   = DATA_W'(8'h1A);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("usid_strap_ctl: DATA_W must be 8");
      end
      if (ID_W != 4) begin : g_bad_id
         $error("usid_strap_ctl: ID_W must be 4");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("usid_strap_ctl: ADDR_W too small for the register map");
      end
      if (GID_LSB < ID_W || GID_LSB >= DATA_W) begin : g_bad_gid
         $error("usid_strap_ctl: GID_LSB out of range");
      end
   endgenerate

   logic [ID_W-1:0] strap_id;

   usid_strap_table #(
      .ID_W (ID_W)
   ) u_table (
      .sel_high  (sel_high),
      .swap_mode (swap_mode),
      .strap_id  (strap_id)
   );

   usid_prog_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ID_W      (ID_W),
      .PID_ADDR  (PID_ADDR),
      .MID_ADDR  (MID_ADDR),
      .USID_ADDR (USID_ADDR),
      .PID_VAL   (PID_VAL),
      .MID_VAL   (MID_VAL)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .strap_id (strap_id),
      .usid     (usid)
   );

   usid_id_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ID_W      (ID_W),
      .GID_LSB   (GID_LSB),
      .READ_REG  (READ_REG),
      .PID_ADDR  (PID_ADDR),
      .MID_ADDR  (MID_ADDR),
      .USID_ADDR (USID_ADDR),
      .EXT_ADDR  (EXT_ADDR),
      .GID_ADDR  (GID_ADDR),
      .PID_VAL   (PID_VAL),
      .MID_VAL   (MID_VAL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .gid_wdata (wdata[DATA_W-1:GID_LSB]),
      .usid      (usid),
      .rdata     (rdata)
   );

endmodule

// File: rtl/usid_strap_ctl_chk.sv
module usid_strap_ctl_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ID_W     = 4,
   parameter bit          READ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_high,
   input logic              swap_mode,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [ID_W-1:0]   usid,
   input logic [DATA_W-1:0] rdata
);
   logic warm;
   logic sel_q;
   logic swap_q;

   always_ff @(posedge clk) begin
      warm   <= rst_n;
      sel_q  <= sel_high;
      swap_q <= swap_mode;
   end

   function automatic logic [3:0] exp_strap(input logic sw, input logic sl);
      case ({sw, sl})
         2'b00:   return 4'b0111;
         2'b01:   return 4'b0110;
         2'b10:   return 4'b1100;
         default: return 4'b0010;
      endcase
   endfunction

   // R1 R2 R3
   strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!warm) |-> (usid == exp_strap(swap_q, sel_q)));

   // R4 R8
   usid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
      !$past(wr_en && !rd_en && (addr == ADDR_W'(8'h1F))) |-> $stable(usid));

   generate
      if (READ_REG) begin : g_rd_chk
         // R6
         id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == ADDR_W'(8'h1D))) |=> (rdata == DATA_W'(8'h32)));

         // R5
         usid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == ADDR_W'(8'h1F))) |=> (rdata[ID_W-1:0] == $past(usid)));

         // R9
         gid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (addr == ADDR_W'(8'h22))) |=> (rdata[3:0] == 4'h0));

         // R5
         rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            !$past(rd_en) |-> $stable(rdata));
      end
   endgenerate

endmodule

bind usid_strap_ctl usid_strap_ctl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ID_W     (ID_W),
   .READ_REG (READ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_high  (sel_high),
   .swap_mode (swap_mode),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .usid      (usid),
   .rdata     (rdata)
);

// File: tb/usid_strap_ctl_tb.sv
module usid_strap_ctl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_high = 1'b0;
   logic       swap_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [3:0] usid;
   logic [7:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usid_strap_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .sel_high(sel_high), .swap_mode(swap_mode),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .usid(usid), .rdata(rdata)
   );

   function automatic logic [3:0] strap_of(input logic sw, input logic sl);
      logic [3:0] t [4];
      t[0] = 4'b0111; t[1] = 4'b0110; t[2] = 4'b1100; t[3] = 4'b0010;
      return t[{sw, sl}];
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic sl, input logic sw);
      @(negedge clk);
      sel_high = sl; swap_mode = sw; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic unlock(input logic [7:0] d);
      wr(8'h1D, 8'h32);
      wr(8'h1E, 8'h1A);
      wr(8'h1F, d);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] cur;

      // Strap sweep: R1 R2 R3 R4 R5 R9
      for (int s = 0; s < 4; s++) begin
         do_reset(s[0], s[1]);
         cur = strap_of(s[1], s[0]);
         if (s[1] == 1'b0 && s[0] == 1'b0) check("R1", {4'h0, usid}, 8'h07);
         else if (s[1] == 1'b0)            check("R2", {4'h0, usid}, 8'h06);
         else                              check("R3", {4'h0, usid}, {4'h0, cur});
         check("R3_rdata_reset", rdata, 8'h00);
         rd(8'h22, v);
         check("R9_reset", v, 8'h00);
         rd(8'h1F, v);
         check("R5", v, {4'b0001, cur});
         repeat (3) @(negedge clk);
         check("R5_hold", rdata, {4'b0001, cur});
         for (int t = 0; t < 4; t++) begin
            sel_high = t[0]; swap_mode = t[1];
            @(negedge clk);
            check("R4", {4'h0, usid}, {4'h0, cur});
         end
      end

      // Program every value for every strap: R7 R5 R10
      for (int s = 0; s < 4; s++) begin
         do_reset(s[0], s[1]);
         for (int k = 0; k < 16; k++) begin
            unlock({4'hA, k[3:0]});
            check("R7", {4'h0, usid}, {4'h0, k[3:0]});
            rd(8'h1F, v);
            check("R7_readback", v, {4'b0001, k[3:0]});
         end
         wr(8'h22, 8'h5C);
         do_reset(s[0], s[1]);
         check("R10", {4'h0, usid}, {4'h0, strap_of(s[1], s[0])});
         rd(8'h22, v);
         check("R10_gid", v, 8'h00);
      end

      // Idle gaps between steps still unlock: R7
      do_reset(1'b0, 1'b0);
      wr(8'h1D, 8'h32); repeat (3) @(negedge clk);
      wr(8'h1E, 8'h1A); repeat (2) @(negedge clk);
      wr(8'h1F, 8'h03);
      check("R7_idle", {4'h0, usid}, 8'h03);

      // Broken sequences: R8
      cur = 4'h3;
      wr(8'h1D, 8'h33); wr(8'h1E, 8'h1A); wr(8'h1F, 8'h09);
      check("R8_bad_pid", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); wr(8'h1E, 8'h1B); wr(8'h1F, 8'h09);
      check("R8_bad_mid", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); rd(8'h00, v); wr(8'h1E, 8'h1A); wr(8'h1F, 8'h09);
      check("R8_read_between", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); wr(8'h1E, 8'h1A); rd(8'h1D, v); wr(8'h1F, 8'h09);
      check("R8_read_late", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); wr(8'h1E, 8'h1A); wr(8'h22, 8'h00); wr(8'h1F, 8'h09);
      check("R8_write_between", {4'h0, usid}, {4'h0, cur});
      wr(8'h1E, 8'h1A); wr(8'h1D, 8'h32); wr(8'h1F, 8'h09);
      check("R8_order", {4'h0, usid}, {4'h0, cur});
      wr(8'h1F, 8'h09);
      check("R8_bare", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); wr(8'h1E, 8'h1A);
      rd_en = 1'b1; wr(8'h1F, 8'h09); rd_en = 1'b0;
      check("R8_both_strobes", {4'h0, usid}, {4'h0, cur});
      wr(8'h1D, 8'h32); wr(8'h1E, 8'h1A); wr(8'h1F, 8'h09); wr(8'h1F, 8'h0E);
      check("R8_second_load", {4'h0, usid}, 8'h09);

      // Identity constants, writes ignored: R6
      wr(8'h1D, 8'hFF); wr(8'h1E, 8'h00); wr(8'h20, 8'hA5);
      rd(8'h1D, v); check("R6_pid", v, 8'h32);
      rd(8'h1E, v); check("R6_mid", v, 8'h1A);
      rd(8'h20, v); check("R6_ext", v, 8'h00);

      // Group nibble sweep: R9
      for (int g = 0; g < 16; g++) begin
         wr(8'h22, {g[3:0], 4'hF - g[3:0]});
         rd(8'h22, v);
         check("R9", v, {g[3:0], 4'h0});
      end

      // Unmapped space: R11 (group nibble is 0xF here)
      for (int a = 0; a < 256; a++) begin
         if (a == 8'h1D || a == 8'h1E || a == 8'h1F || a == 8'h20 || a == 8'h22) continue;
         rd(a[7:0], v);
         check("R11", v, 8'h00);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule